// File: doc/BRIEF.md
# Fixed-Point Saturating PID Controller

This block is a discrete-time proportional-integral-derivative controller for a voltage regulation loop. For each accepted control tick it takes a signed normalized set point and a measured voltage sample, both Q1.15, plus three signed Q4.12 gains. It forms the control error, advances a clamped integral accumulator, and optionally adds a derivative term from the change in error since the previous tick. The three weighted terms are combined at full width and clamped into a Q2.15 control word, which appears with a one-cycle valid strobe.

Every update takes the same number of cycles whatever the data, so the loop delay is fixed. Each narrowing point clamps to the most positive or most negative value of its target format rather than wrapping. Samples that arrive while an update is in flight are dropped, which limits the accepted rate to one sample every three cycles.

Top module: `pid_sat_ctrl`

## Requirements
- R1: The error is set point minus measurement, held as a 17-bit signed Q2.15 value, so the full input range (for example -1.0 minus (1.0 - 2^-15) = -65535 LSB) is exact.
- R2: The integral accumulator is a 19-bit signed Q4.15 value that adds the current error on each accepted sample and is clamped to the range -262144..262143; it never wraps.
- R3: The derivative contribution is Kd times (error minus previous error), with the previous error being zero after reset; with parameter USE_DERIV = 0 this contribution is absent.
- R4: Each gain product (gain Q4.12 times operand) is formed at full width and shifted right by 12 with rounding toward negative infinity, and the three shifted terms are summed at full width.
- R5: The control output is a 17-bit signed Q2.15 value equal to the full-width sum clamped to -65536..65535.
- R6: out_valid_o pulses high for exactly one cycle, in the third cycle after the cycle in which a sample was accepted; ctrl_o holds its value between pulses.
- R7: A sample_valid_i pulse in either of the two cycles after an accepted sample is ignored: it changes no state and produces no extra out_valid_o pulse.
- R8: Reset clears the integral accumulator, the stored previous error, ctrl_o and out_valid_o to zero.
- R9: Gains are captured when a sample is accepted; the update uses those captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe that starts an update |
| ref_i | input | 16 | Set point, signed Q1.15 |
| meas_i | input | 16 | Measured voltage, signed Q1.15 |
| kp_i | input | 16 | Proportional gain, signed Q4.12 |
| ki_i | input | 16 | Integral gain, signed Q4.12 |
| kd_i | input | 16 | Derivative gain, signed Q4.12 |
| ctrl_o | output | 17 | Control output, signed Q2.15 |
| out_valid_o | output | 1 | One-cycle strobe marking a new ctrl_o |

## Verification
The assertions assume that sample_valid_i is a strobe the block may see at any time, including while busy. They also assume that gain and data inputs are stable in the cycle a strobe is accepted. The bench drives every input half a cycle away from the active edge. It deliberately raises sample_valid_i in both busy cycles of every third update, so the busy-drop properties are exercised rather than taken on trust. The stimulus walks a grid of corner values, including both input extremes, under several gain sets, and adds a long run of same-sign errors that drives the accumulator into both clamps.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned PID_DATA_W    = 16;
  localparam int unsigned PID_GAIN_W    = 16;
  localparam int unsigned PID_GAIN_FRAC = 12;
  localparam int unsigned PID_ACC_GUARD = 2;   // integer bits of accumulator above error
  localparam int unsigned PID_LATENCY   = 3;
endpackage

// File: rtl/pid_clamp.sv
module pid_clamp #(
  parameter int unsigned IN_W  = 20,
  parameter int unsigned OUT_W = 19
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);
  logic [IN_W-OUT_W:0] hi;
  logic                fits;

  assign hi   = in_i[IN_W-1:OUT_W-1];
  assign fits = (&hi) | ~(|hi);

  always_comb begin
    if (fits)             out_o = in_i[OUT_W-1:0];
    else if (in_i[IN_W-1]) out_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                  out_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/pid_err_integ.sv
module pid_err_integ #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 16,
  parameter int unsigned ACC_W  = 19,
  localparam int unsigned ERR_W  = DATA_W + 1,
  localparam int unsigned DERR_W = ERR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] meas_i,
  input  logic [GAIN_W-1:0] kp_i,
  input  logic [GAIN_W-1:0] ki_i,
  input  logic [GAIN_W-1:0] kd_i,
  output logic [ERR_W-1:0]  err_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic [DERR_W-1:0] derr_o,
  output logic [GAIN_W-1:0] kp_o,
  output logic [GAIN_W-1:0] ki_o,
  output logic [GAIN_W-1:0] kd_o,
  output logic              valid_o
);
  logic [ERR_W-1:0]  err_n;
  logic [DERR_W-1:0] derr_n;
  logic [ACC_W:0]    acc_sum;
  logic [ACC_W-1:0]  acc_sat;

  assign err_n   = {ref_i[DATA_W-1], ref_i} - {meas_i[DATA_W-1], meas_i};
  // err_o doubles as the previous error for the next derivative
  assign derr_n  = {err_n[ERR_W-1], err_n} - {err_o[ERR_W-1], err_o};
  assign acc_sum = {acc_o[ACC_W-1], acc_o} + {{(ACC_W+1-ERR_W){err_n[ERR_W-1]}}, err_n};

  pid_clamp #(.IN_W(ACC_W+1), .OUT_W(ACC_W)) u_acc_clamp (
    .in_i (acc_sum),
    .out_o(acc_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= '0;
      acc_o   <= '0;
      derr_o  <= '0;
      kp_o    <= '0;
      ki_o    <= '0;
      kd_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= accept_i;
      if (accept_i) begin
        err_o  <= err_n;
        acc_o  <= acc_sat;
        derr_o <= derr_n;
        kp_o   <= kp_i;
        ki_o   <= ki_i;
        kd_o   <= kd_i;
      end
    end
  end
endmodule

// File: rtl/pid_term.sv
module pid_term #(
  parameter int unsigned A_W   = 16,
  parameter int unsigned B_W   = 17,
  parameter int unsigned FRAC  = 12,
  parameter int unsigned SUM_W = 37,
  localparam int unsigned PW   = A_W + B_W
) (
  input  logic [A_W-1:0]   gain_i,
  input  logic [B_W-1:0]   opnd_i,
  output logic [SUM_W-1:0] term_o
);
  logic signed [PW-1:0] a_x, b_x, prod, shd;

  assign a_x    = {{(PW-A_W){gain_i[A_W-1]}}, gain_i};
  assign b_x    = {{(PW-B_W){opnd_i[B_W-1]}}, opnd_i};
  assign prod   = a_x * b_x;
  assign shd    = prod >>> FRAC;   // floor division by 2^FRAC
  assign term_o = {{(SUM_W-PW){shd[PW-1]}}, shd};
endmodule

// File: rtl/pid_gain_mul.sv
module pid_gain_mul #(
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 12,
  parameter int unsigned ERR_W     = 17,
  parameter int unsigned ACC_W     = 19,
  parameter int unsigned SUM_W     = 37,
  parameter bit          USE_DERIV = 1'b1,
  localparam int unsigned DERR_W   = ERR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [DERR_W-1:0] derr_i,
  input  logic [GAIN_W-1:0] kp_i,
  input  logic [GAIN_W-1:0] ki_i,
  input  logic [GAIN_W-1:0] kd_i,
  output logic [SUM_W-1:0]  p_o,
  output logic [SUM_W-1:0]  i_o,
  output logic [SUM_W-1:0]  d_o,
  output logic              valid_o
);
  logic [SUM_W-1:0] p_n, i_n, d_n;

  pid_term #(.A_W(GAIN_W), .B_W(ERR_W), .FRAC(GAIN_FRAC), .SUM_W(SUM_W)) u_p_term (
    .gain_i(kp_i), .opnd_i(err_i), .term_o(p_n)
  );
  pid_term #(.A_W(GAIN_W), .B_W(ACC_W), .FRAC(GAIN_FRAC), .SUM_W(SUM_W)) u_i_term (
    .gain_i(ki_i), .opnd_i(acc_i), .term_o(i_n)
  );

  generate
    if (USE_DERIV) begin : g_deriv
      pid_term #(.A_W(GAIN_W), .B_W(DERR_W), .FRAC(GAIN_FRAC), .SUM_W(SUM_W)) u_d_term (
        .gain_i(kd_i), .opnd_i(derr_i), .term_o(d_n)
      );
    end else begin : g_no_deriv
      assign d_n = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o     <= '0;
      i_o     <= '0;
      d_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        p_o <= p_n;
        i_o <= i_n;
        d_o <= d_n;
      end
    end
  end
endmodule

// File: rtl/pid_out_sat.sv
module pid_out_sat #(
  parameter int unsigned SUM_W = 37,
  parameter int unsigned OUT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SUM_W-1:0] p_i,
  input  logic [SUM_W-1:0] i_i,
  input  logic [SUM_W-1:0] d_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [OUT_W-1:0] ctrl_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] ctrl_n;

  assign sum_o = p_i + i_i + d_i;

  pid_clamp #(.IN_W(SUM_W), .OUT_W(OUT_W)) u_out_clamp (
    .in_i (sum_o),
    .out_o(ctrl_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) ctrl_o <= ctrl_n;
    end
  end
endmodule

// File: rtl/pid_sat_ctrl.sv
module pid_sat_ctrl
  import pid_pkg::*;
#(
  parameter int unsigned DATA_W    = PID_DATA_W,
  parameter int unsigned GAIN_W    = PID_GAIN_W,
  parameter int unsigned GAIN_FRAC = PID_GAIN_FRAC,
  parameter bit          USE_DERIV = 1'b1,
  localparam int unsigned ERR_W    = DATA_W + 1,
  localparam int unsigned DERR_W   = ERR_W + 1,
  localparam int unsigned ACC_W    = ERR_W + PID_ACC_GUARD,
  localparam int unsigned OUT_W    = ERR_W,
  localparam int unsigned SUM_W    = GAIN_W + ACC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] meas_i,
  input  logic [GAIN_W-1:0] kp_i,
  input  logic [GAIN_W-1:0] ki_i,
  input  logic [GAIN_W-1:0] kd_i,
  output logic [OUT_W-1:0]  ctrl_o,
  output logic              out_valid_o
);
  logic              v1, v2, busy, accept;
  logic [ERR_W-1:0]  err_q;
  logic [ACC_W-1:0]  acc_q;
  logic [DERR_W-1:0] derr_q;
  logic [GAIN_W-1:0] kp_q, ki_q, kd_q;
  logic [SUM_W-1:0]  p_q, i_q, d_q, sum_full;

  assign busy   = v1 | v2;
  assign accept = sample_valid_i & ~busy;

  pid_err_integ #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W)) u_stage1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .ref_i   (ref_i),
    .meas_i  (meas_i),
    .kp_i    (kp_i),
    .ki_i    (ki_i),
    .kd_i    (kd_i),
    .err_o   (err_q),
    .acc_o   (acc_q),
    .derr_o  (derr_q),
    .kp_o    (kp_q),
    .ki_o    (ki_q),
    .kd_o    (kd_q),
    .valid_o (v1)
  );

  pid_gain_mul #(
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .ERR_W(ERR_W),
    .ACC_W(ACC_W), .SUM_W(SUM_W), .USE_DERIV(USE_DERIV)
  ) u_stage2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(v1),
    .err_i  (err_q),
    .acc_i  (acc_q),
    .derr_i (derr_q),
    .kp_i   (kp_q),
    .ki_i   (ki_q),
    .kd_i   (kd_q),
    .p_o    (p_q),
    .i_o    (i_q),
    .d_o    (d_q),
    .valid_o(v2)
  );

  pid_out_sat #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_stage3 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(v2),
    .p_i    (p_q),
    .i_i    (i_q),
    .d_i    (d_q),
    .sum_o  (sum_full),
    .ctrl_o (ctrl_o),
    .valid_o(out_valid_o)
  );
endmodule

// File: rtl/pid_sat_ctrl_chk.sv
module pid_sat_ctrl_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ERR_W  = 17,
  parameter int unsigned ACC_W  = 19,
  parameter int unsigned OUT_W  = 17,
  parameter int unsigned SUM_W  = 37
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic              accept,
  input logic              busy,
  input logic              v2,
  input logic [DATA_W-1:0] ref_i,
  input logic [DATA_W-1:0] meas_i,
  input logic [ERR_W-1:0]  err_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [SUM_W-1:0]  sum_full,
  input logic [OUT_W-1:0]  ctrl_o,
  input logic              out_valid_o
);
  localparam logic signed [SUM_W-1:0] S_MAX = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_MIN = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] O_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] O_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  a_r1_err_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> $signed(err_q) == $signed({$past(ref_i[DATA_W-1]), $past(ref_i)})
                               - $signed({$past(meas_i[DATA_W-1]), $past(meas_i)}));

  a_r2_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(acc_q));

  a_r5_clamp_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 && ($signed(sum_full) > S_MAX) |=> ctrl_o == O_MAX);

  a_r5_clamp_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 && ($signed(sum_full) < S_MIN) |=> ctrl_o == O_MIN);

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ##3 out_valid_o);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(ctrl_o));

  a_r7_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && busy |=> $stable(acc_q) && $stable(err_q));
endmodule

bind pid_sat_ctrl pid_sat_ctrl_chk #(
  .DATA_W(DATA_W), .ERR_W(ERR_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SUM_W(SUM_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .accept        (accept),
  .busy          (busy),
  .v2            (v2),
  .ref_i         (ref_i),
  .meas_i        (meas_i),
  .err_q         (err_q),
  .acc_q         (acc_q),
  .sum_full      (sum_full),
  .ctrl_o        (ctrl_o),
  .out_valid_o   (out_valid_o)
);

// File: tb/pid_sat_ctrl_bench.sv
`timescale 1ns/1ps
module pid_sat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sv = 1'b0;
  logic [15:0] ref_v = '0, meas_v = '0, kp = '0, ki = '0, kd = '0;
  logic [16:0] ctrl_a, ctrl_b;
  logic        ov_a, ov_b;

  int checks = 0;
  int failures = 0;
  longint acc_m, ep_m, exp_a, exp_b;

  always #10 clk = ~clk;

  pid_sat_ctrl u_pid_sat_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sv), .ref_i(ref_v), .meas_i(meas_v),
    .kp_i(kp), .ki_i(ki), .kd_i(kd), .ctrl_o(ctrl_a), .out_valid_o(ov_a)
  );

  pid_sat_ctrl #(.USE_DERIV(1'b0)) u_pid_sat_ctrl_nod (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sv), .ref_i(ref_v), .meas_i(meas_v),
    .kp_i(kp), .ki_i(ki), .kd_i(kd), .ctrl_o(ctrl_b), .out_valid_o(ov_b)
  );

  function automatic longint clampv(longint x, longint lo, longint hi);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  function automatic longint sx(logic [16:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of one accepted update
  task automatic model_step(int r, int m);
    longint e, de, pt, it, dt, kpl, kil, kdl;
    kpl = longint'($signed(kp)); kil = longint'($signed(ki)); kdl = longint'($signed(kd));
    e = longint'(r) - longint'(m);
    acc_m = clampv(acc_m + e, -262144, 262143);
    de = e - ep_m;
    ep_m = e;
    pt = (kpl * e) >>> 12;
    it = (kil * acc_m) >>> 12;
    dt = (kdl * de) >>> 12;
    exp_a = clampv(pt + it + dt, -65536, 65535);
    exp_b = clampv(pt + it, -65536, 65535);
  endtask

  task automatic do_reset();
    @(negedge clk);
    sv = 1'b0;
    rst_ni = 1'b0;
    acc_m = 0; ep_m = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    chk(ctrl_a == '0, "R8 ctrl after reset", sx(ctrl_a), 0);
    chk(ov_a == 1'b0 && ov_b == 1'b0, "R8 valid after reset", longint'(ov_a), 0);
  endtask

  task automatic do_sample(int r, int m, bit inj, string tag);
    logic [15:0] kp_s;
    @(negedge clk);
    ref_v = r[15:0]; meas_v = m[15:0]; sv = 1'b1;
    model_step(r, m);
    kp_s = kp;
    @(negedge clk);
    sv = 1'b0;
    chk(!ov_a && !ov_b, "R6 no early valid c1", longint'(ov_a), 0);
    if (inj) begin
      ref_v = ~r[15:0]; meas_v = 16'h04d2; kp = ~kp_s; sv = 1'b1;
    end
    @(negedge clk);
    chk(!ov_a && !ov_b, "R6 no early valid c2", longint'(ov_a), 0);
    if (inj) begin
      ref_v = 16'h8000; meas_v = 16'h7fff; sv = 1'b1;
    end
    @(negedge clk);
    sv = 1'b0; kp = kp_s;
    chk(ov_a && ov_b, "R6 valid at third cycle", longint'(ov_a), 1);
    chk(sx(ctrl_a) == exp_a, inj ? "R7 busy sample ignored (R9)" : tag, sx(ctrl_a), exp_a);
    chk(sx(ctrl_b) == exp_b, "R3 derivative disabled", sx(ctrl_b), exp_b);
    @(negedge clk);
    chk(!ov_a && !ov_b, inj ? "R7 no extra valid" : "R6 single pulse", longint'(ov_a), 0);
    chk(sx(ctrl_a) == exp_a, "R6 output held", sx(ctrl_a), exp_a);
  endtask

  int grid [7] = '{-32768, -16384, -1, 0, 1, 12345, 32767};
  int gp [5] = '{4096, 2048, -4096, 32767, 0};
  int gi [5] = '{0, 512, 4096, 32767, 1024};
  int gd [5] = '{0, 1024, -8192, 32767, 0};
  string gtag [5] = '{"R1 error exact", "R4 term sum", "R3 derivative", "R5 output clamp", "R2 integral"};

  initial begin : main
    int n;
    n = 0;
    for (int g = 0; g < 5; g++) begin
      kp = gp[g][15:0]; ki = gi[g][15:0]; kd = gd[g][15:0];
      do_reset();
      for (int a = 0; a < 7; a++) begin
        for (int b = 0; b < 7; b++) begin
          do_sample(grid[a], grid[b], (n % 3) == 2, gtag[g]);
          n++;
        end
      end
    end
    // R2: integral wind-up into both clamps, then recovery
    kp = 16'd0; ki = 16'd1024; kd = 16'd0;
    do_reset();
    for (int k = 0; k < 12; k++) do_sample(32767, -32768, 1'b0, "R2 clamp high");
    for (int k = 0; k < 12; k++) do_sample(-32768, 32767, 1'b0, "R2 clamp low");
    for (int k = 0; k < 3; k++) do_sample(32767, -32768, 1'b0, "R2 unwind");
    // R1: extreme error with unit proportional gain
    kp = 16'd4096; ki = 16'd0; kd = 16'd0;
    do_reset();
    do_sample(-32768, 32767, 1'b0, "R1 min error");
    do_sample(32767, -32768, 1'b0, "R1 max error");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule